// File: doc/BRIEF.md
# TLB Invalidate and Sync Snoop Responder

This block sits on the snoop side of a processor's bus interface and reacts to three address-only coherency transactions, none of which has a data phase. The bus side presents a one-cycle start strobe together with an already decoded transaction type and the bus address. A TLB-invalidate broadcast makes the block extract an 8-bit congruence-class index from the address and pass it to the local TLB as a one-cycle registered invalidate strobe.

The block also keeps a small table of this agent's outstanding operations, each tagged with the translation index it used. A TLB-invalidate whose index hits an outstanding entry marks that entry as relying on a dead translation. A SYNC is retried while snooped cache operations are still pending, and, in the default variant, also while any marked entry exists. A TLBSYNC is retried only while a marked entry exists. The retry response is issued in a fixed window two cycles after the start strobe. One parameter removes SYNC and TLBSYNC snooping altogether; another drops the stale-entry rule from SYNC.

Top module: `tlb_sync_snooper`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, inv_strobe and artry are low and the operation table holds no entries, so a TLBSYNC issued straight after reset gets no retry.
- R2: A start strobe with type 3'b001 (TLB invalidate) makes inv_strobe high in the next cycle, with inv_index equal to ts_addr[19:12] (bus address bits 12 to 19 counted from the most significant bit).
- R3: A TLB invalidate never causes artry, and type codes other than 3'b001, 3'b010 and 3'b011 cause neither inv_strobe nor artry.
- R4: A start strobe with type 3'b010 (SYNC) makes artry high two cycles later when cache_snoop_pend is high in the cycle after the strobe.
- R5: When SYNC_STALE_RETRY is 1 (the default), a SYNC also gets artry while any outstanding entry is marked stale. When it is 0, stale entries have no effect on SYNC.
- R6: A start strobe with type 3'b011 (TLBSYNC) makes artry high two cycles later if and only if an outstanding entry is marked stale. cache_snoop_pend has no effect on TLBSYNC.
- R7: A TLB invalidate marks as stale exactly those outstanding entries whose recorded index equals the invalidated index. Entries with a different index stay unmarked.
- R8: Completing an operation (op_done with its id) frees its entry and clears its stale mark, so a later TLBSYNC is no longer retried because of it.
- R9: When SYNC_SNOOP is 0, artry is never asserted for SYNC or TLBSYNC, and TLB invalidates still produce inv_strobe and inv_index.
- R10: artry and inv_strobe are registered and last one cycle per transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_valid | input | 1 | Transaction start strobe, one cycle |
| ts_type | input | 3 | Decoded transaction type: 1 invalidate, 2 SYNC, 3 TLBSYNC |
| ts_addr | input | ADDR_W | Bus address of the transaction |
| cache_snoop_pend | input | 1 | Snooped cache operations are still pending in this agent |
| op_alloc | input | 1 | Record a new outstanding operation |
| op_alloc_id | input | OP_ID_W | Table slot of the new operation |
| op_alloc_idx | input | IDX_W | Translation index used by the new operation |
| op_done | input | 1 | An outstanding operation completed |
| op_done_id | input | OP_ID_W | Table slot of the completed operation |
| inv_strobe | output | 1 | One-cycle invalidate request to the local TLB |
| inv_index | output | IDX_W | Congruence class to invalidate |
| artry | output | 1 | Address retry response |

## Verification
The assertions assume that a start strobe lasts one cycle and that ts_type and ts_addr are meaningful only while it is high. They also assume that op_done names a slot that was allocated earlier, and that a slot is not reallocated while it is still outstanding. The stimulus separates transactions by at least three idle cycles, changes cache_snoop_pend only between transactions, and allocates and completes each table slot exactly once. Under these conditions every retry window belongs to a single transaction.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [2:0] {
    TT_OTHER   = 3'd0,
    TT_TLBINV  = 3'd1,
    TT_SYNC    = 3'd2,
    TT_TLBSYNC = 3'd3
  } txn_t;
endpackage

// File: rtl/snoop_decode.sv
module snoop_decode
  import snoop_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ts_valid,
  input  logic [2:0]       ts_type,
  input  logic [IDX_W-1:0] ts_idx,
  output logic             s_vld,
  output logic [2:0]       s_type,
  output logic             inv_strobe,
  output logic [IDX_W-1:0] inv_index
);
  logic is_inv;
  assign is_inv = ts_valid && (ts_type == TT_TLBINV);

  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld      <= 1'b0;
      s_type     <= TT_OTHER;
      inv_strobe <= 1'b0;
      inv_index  <= '0;
    end else begin
      s_vld      <= ts_valid;
      s_type     <= ts_valid ? ts_type : TT_OTHER;
      inv_strobe <= is_inv;
      inv_index  <= is_inv ? ts_idx : '0;
    end
  end

  // R2: strobe only after an invalidate start
  a_r2_inv_follows_start: assert property (@(posedge clk) disable iff (rst)
    inv_strobe |-> $past(ts_valid && ts_type == TT_TLBINV));
  // R2: index taken from the address of that start
  a_r2_inv_index: assert property (@(posedge clk) disable iff (rst)
    inv_strobe |-> inv_index == $past(ts_idx));
endmodule

// File: rtl/stale_tracker.sv
module stale_tracker #(
  parameter int IDX_W   = 8,
  parameter int OP_ID_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_alloc,
  input  logic [OP_ID_W-1:0] op_alloc_id,
  input  logic [IDX_W-1:0]   op_alloc_idx,
  input  logic               op_done,
  input  logic [OP_ID_W-1:0] op_done_id,
  input  logic               inv_strobe,
  input  logic [IDX_W-1:0]   inv_index,
  output logic               any_stale
);
  localparam int NUM_OPS = 1 << OP_ID_W;

  logic             vld [NUM_OPS];
  logic             stl [NUM_OPS];
  logic [IDX_W-1:0] idx [NUM_OPS];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_ent
    logic hit_alloc, hit_done;
    assign hit_alloc = op_alloc && (op_alloc_id == OP_ID_W'(i));
    assign hit_done  = op_done  && (op_done_id  == OP_ID_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i] <= 1'b0;
        stl[i] <= 1'b0;
        idx[i] <= '0;
      end else if (hit_alloc) begin
        vld[i] <= 1'b1;
        idx[i] <= op_alloc_idx;
        stl[i] <= inv_strobe && (inv_index == op_alloc_idx);
      end else if (hit_done) begin
        vld[i] <= 1'b0;
        stl[i] <= 1'b0;
      end else if (vld[i] && inv_strobe && (inv_index == idx[i])) begin
        stl[i] <= 1'b1;
      end
    end

    // R8: completion clears the mark
    a_r8_done_clears: assert property (@(posedge clk) disable iff (rst)
      (hit_done && !hit_alloc) |=> !stl[i]);
    // R7: a mark appears only after an invalidate
    a_r7_mark_needs_inv: assert property (@(posedge clk) disable iff (rst)
      $rose(stl[i]) |-> $past(inv_strobe));
  end

  always_comb begin
    any_stale = 1'b0;
    for (int k = 0; k < NUM_OPS; k++) any_stale |= vld[k] && stl[k];
  end
endmodule

// File: rtl/retry_gen.sv
module retry_gen
  import snoop_pkg::*;
#(
  parameter bit SYNC_SNOOP       = 1'b1,
  parameter bit SYNC_STALE_RETRY = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       s_vld,
  input  logic [2:0] s_type,
  input  logic       cache_snoop_pend,
  input  logic       any_stale,
  output logic       artry
);
  logic need;

  always_comb begin
    need = 1'b0;
    if (SYNC_SNOOP && s_vld) begin
      case (s_type)
        TT_SYNC:    need = cache_snoop_pend || (SYNC_STALE_RETRY && any_stale);
        TT_TLBSYNC: need = any_stale;
        default:    need = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) artry <= 1'b0;
    else     artry <= need;
  end

  // R3: invalidates never draw a retry
  a_r3_inv_no_retry: assert property (@(posedge clk) disable iff (rst)
    (s_vld && s_type == TT_TLBINV) |=> !artry);
  // R6: clean table means no TLBSYNC retry
  a_r6_tlbsync_clean: assert property (@(posedge clk) disable iff (rst)
    (s_vld && s_type == TT_TLBSYNC && !any_stale) |=> !artry);
  // R4: a SYNC with pending cache snoops is retried
  a_r4_sync_pend: assert property (@(posedge clk) disable iff (rst)
    (s_vld && s_type == TT_SYNC && cache_snoop_pend && SYNC_SNOOP) |=> artry);

  if (!SYNC_SNOOP) begin : g_nosnoop
    // R9: sync types are ignored in this variant
    a_r9_no_sync_retry: assert property (@(posedge clk) disable iff (rst)
      (s_vld && (s_type == TT_SYNC || s_type == TT_TLBSYNC)) |=> !artry);
  end
endmodule

// File: rtl/tlb_sync_snooper.sv
module tlb_sync_snooper #(
  parameter int ADDR_W           = 32,
  parameter int IDX_LSB          = 12,
  parameter int IDX_W            = 8,
  parameter int OP_ID_W          = 2,
  parameter bit SYNC_SNOOP       = 1'b1,
  parameter bit SYNC_STALE_RETRY = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ts_valid,
  input  logic [2:0]         ts_type,
  input  logic [ADDR_W-1:0]  ts_addr,
  input  logic               cache_snoop_pend,
  input  logic               op_alloc,
  input  logic [OP_ID_W-1:0] op_alloc_id,
  input  logic [IDX_W-1:0]   op_alloc_idx,
  input  logic               op_done,
  input  logic [OP_ID_W-1:0] op_done_id,
  output logic               inv_strobe,
  output logic [IDX_W-1:0]   inv_index,
  output logic               artry
);
  logic [IDX_W-1:0] ts_idx;
  logic             s_vld, any_stale;
  logic [2:0]       s_type;
  logic             unused_addr;

  assign ts_idx      = ts_addr[IDX_LSB +: IDX_W];
  assign unused_addr = ^ts_addr;

  snoop_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_type(ts_type),
    .ts_idx(ts_idx), .s_vld(s_vld), .s_type(s_type),
    .inv_strobe(inv_strobe), .inv_index(inv_index)
  );

  stale_tracker #(.IDX_W(IDX_W), .OP_ID_W(OP_ID_W)) u_trk (
    .clk(clk), .rst(rst), .op_alloc(op_alloc), .op_alloc_id(op_alloc_id),
    .op_alloc_idx(op_alloc_idx), .op_done(op_done), .op_done_id(op_done_id),
    .inv_strobe(inv_strobe), .inv_index(inv_index), .any_stale(any_stale)
  );

  retry_gen #(.SYNC_SNOOP(SYNC_SNOOP), .SYNC_STALE_RETRY(SYNC_STALE_RETRY)) u_rty (
    .clk(clk), .rst(rst), .s_vld(s_vld), .s_type(s_type),
    .cache_snoop_pend(cache_snoop_pend), .any_stale(any_stale), .artry(artry)
  );

  // R10: one retry pulse per transaction when starts are spaced apart
  a_r10_retry_single: assert property (@(posedge clk) disable iff (rst)
    (artry && !$past(ts_valid)) |=> !artry);
  // R1: outputs quiet in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!artry && !inv_strobe));
endmodule

// File: tb/sim_tlb_sync_snooper.sv
module sim_tlb_sync_snooper;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ts_valid = 1'b0;
  logic [2:0]  ts_type = 3'd0;
  logic [31:0] ts_addr = '0;
  logic        pend = 1'b0;
  logic        op_alloc = 1'b0, op_done = 1'b0;
  logic [1:0]  op_alloc_id = '0, op_done_id = '0;
  logic [7:0]  op_alloc_idx = '0;
  logic        inv0, inv1, inv2, art0, art1, art2;
  logic [7:0]  idx0, idx1, idx2;

  int errors = 0;
  int checks = 0;
  logic       s_inv, s_inv1, s_inv_after, s_a0, s_a1, s_a2, s_a_after;
  logic [7:0] s_idx;

  always #2 clk = ~clk;

  tlb_sync_snooper u0 (
    .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_type(ts_type), .ts_addr(ts_addr),
    .cache_snoop_pend(pend), .op_alloc(op_alloc), .op_alloc_id(op_alloc_id),
    .op_alloc_idx(op_alloc_idx), .op_done(op_done), .op_done_id(op_done_id),
    .inv_strobe(inv0), .inv_index(idx0), .artry(art0));

  tlb_sync_snooper #(.SYNC_SNOOP(1'b0)) u1 (
    .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_type(ts_type), .ts_addr(ts_addr),
    .cache_snoop_pend(pend), .op_alloc(op_alloc), .op_alloc_id(op_alloc_id),
    .op_alloc_idx(op_alloc_idx), .op_done(op_done), .op_done_id(op_done_id),
    .inv_strobe(inv1), .inv_index(idx1), .artry(art1));

  tlb_sync_snooper #(.SYNC_STALE_RETRY(1'b0)) u2 (
    .clk(clk), .rst(rst), .ts_valid(ts_valid), .ts_type(ts_type), .ts_addr(ts_addr),
    .cache_snoop_pend(pend), .op_alloc(op_alloc), .op_alloc_id(op_alloc_id),
    .op_alloc_idx(op_alloc_idx), .op_done(op_done), .op_done_id(op_done_id),
    .inv_strobe(inv2), .inv_index(idx2), .artry(art2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [2:0] t, input logic [31:0] a);
    @(negedge clk); ts_valid = 1'b1; ts_type = t; ts_addr = a;
    @(negedge clk); ts_valid = 1'b0; ts_type = 3'd0; ts_addr = '0;
    s_inv = inv0; s_idx = idx0; s_inv1 = inv1;
    @(negedge clk);
    s_a0 = art0; s_a1 = art1; s_a2 = art2; s_inv_after = inv0;
    @(negedge clk);
    s_a_after = art0;
  endtask

  task automatic alloc_op(input logic [1:0] id, input logic [7:0] ix);
    @(negedge clk); op_alloc = 1'b1; op_alloc_id = id; op_alloc_idx = ix;
    @(negedge clk); op_alloc = 1'b0;
  endtask

  task automatic done_op(input logic [1:0] id);
    @(negedge clk); op_done = 1'b1; op_done_id = id;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 artry in reset", 32'(art0), 0);
    chk("R1 inv_strobe in reset", 32'(inv0), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 artry after reset", 32'(art0), 0);
    run_txn(3'd3, 32'h0);
    chk("R1 TLBSYNC on empty table", 32'(s_a0), 0);
  endtask

  task automatic t_invalidate;
    run_txn(3'd1, 32'h000A_5000);
    chk("R2 inv_strobe", 32'(s_inv), 1);
    chk("R2 inv_index", 32'(s_idx), 32'hA5);
    chk("R3 no retry on invalidate", 32'(s_a0), 0);
    chk("R10 inv_strobe one cycle", 32'(s_inv_after), 0);
    chk("R9 invalidate with sync snooping off", 32'(s_inv1), 1);
  endtask

  task automatic t_sync_pending;
    pend = 1'b1;
    run_txn(3'd2, 32'h0);
    chk("R4 SYNC with pending snoops", 32'(s_a0), 1);
    chk("R10 artry one cycle", 32'(s_a_after), 0);
    chk("R9 SYNC ignored when snooping off", 32'(s_a1), 0);
    run_txn(3'd3, 32'h0);
    chk("R6 TLBSYNC ignores pending snoops", 32'(s_a0), 0);
    run_txn(3'd5, 32'h000F_F000);
    chk("R3 other type no strobe", 32'(s_inv), 0);
    chk("R3 other type no retry", 32'(s_a0), 0);
    pend = 1'b0;
    run_txn(3'd2, 32'h0);
    chk("R4 SYNC with nothing pending", 32'(s_a0), 0);
  endtask

  task automatic t_stale;
    alloc_op(2'd0, 8'h33);
    alloc_op(2'd1, 8'h44);
    run_txn(3'd1, 32'h0005_5000);
    run_txn(3'd3, 32'h0);
    chk("R7 non-matching invalidate leaves table clean", 32'(s_a0), 0);
    run_txn(3'd1, 32'h0003_3000);
    run_txn(3'd3, 32'h0);
    chk("R6 TLBSYNC with stale entry", 32'(s_a0), 1);
    chk("R9 TLBSYNC ignored when snooping off", 32'(s_a1), 0);
    chk("R6 TLBSYNC stale in no-stale-SYNC variant", 32'(s_a2), 1);
    run_txn(3'd2, 32'h0);
    chk("R5 SYNC with stale entry", 32'(s_a0), 1);
    chk("R5 SYNC stale rule disabled", 32'(s_a2), 0);
    done_op(2'd0);
    run_txn(3'd3, 32'h0);
    chk("R8 completion clears stale", 32'(s_a0), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_invalidate();
    t_sync_pending();
    t_stale();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule